// File: doc/BRIEF.md
# ADC Result Register with Paired Byte Readout

This block stores the most recent 10-bit conversion result and exposes it to an 8-bit bus as two byte views: a low byte and a high byte. A conversion sequencer delivers each finished result as a one-cycle valid pulse with its data. The bus side reads the two bytes with separate read strobes. An alignment select chooses how the 10 bits are spread across the two bytes. When the select is clear the result is right-adjusted, which is the reset value of the select. When the select is set the result is left-adjusted. Code 0x000 stands for ground and code 0x3FF stands for the reference minus one LSB.

A two-byte read always returns two halves of the same result, even while the sequencer keeps finishing conversions. A low-byte read locks the register, and the matching high-byte read releases it. Any result that arrives while the register is locked is dropped, and the block flags the drop with a one-cycle pulse. Software that needs only 8 bits can use the left-adjusted view and read just the high byte. That read never locks the register.

Top module: `adc_result_latch`

## Requirements
- R1: After reset, the stored result is 0, both byte views read 0x00, the register is unlocked and `lost` is low.
- R2: A `res_valid` pulse on a cycle where the register is not held is stored at that clock edge. Its data appears on the byte views from the following cycle.
- R3: When `left_adj` is 0, `lo_byte` equals result bits 7:0, `hi_byte` bits 1:0 equal result bits 9:8, and `hi_byte` bits 7:2 read 0.
- R4: When `left_adj` is 1, `hi_byte` equals result bits 9:2, `lo_byte` bits 7:6 equal result bits 1:0, and `lo_byte` bits 5:0 read 0.
- R5: A change of `left_adj` changes both byte views in the same cycle, with no clock edge needed. The change never alters the stored result.
- R6: A cycle with `rd_lo` high and `rd_hi` low locks the register at that edge. From that edge on, the stored value does not change until a cycle with `rd_hi` high. A result arriving in the `rd_lo` cycle itself is also refused.
- R7: A result refused by the lock makes `lost` high for exactly the one cycle after the refusing edge. At all other times `lost` is low.
- R8: `rd_hi` without an earlier unmatched `rd_lo` shows the current value and leaves the register unlocked. Later results are still captured.
- R9: A cycle with `rd_hi` high releases the lock. A result arriving in that same cycle is accepted. `rd_lo` and `rd_hi` high together leave the register unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion finished, one-cycle pulse |
| res_data | input | 10 | Finished conversion code |
| left_adj | input | 1 | 1 selects left-adjusted views, 0 selects right-adjusted views |
| rd_lo | input | 1 | Low byte is being read this cycle |
| rd_hi | input | 1 | High byte is being read this cycle |
| lo_byte | output | 8 | Low byte view |
| hi_byte | output | 8 | High byte view |
| lost | output | 1 | A result was dropped at the previous edge |

## Verification
The byte views are combinational from the stored result and `left_adj`, so alignment effects are due in the same cycle. A stored result is due one clock edge after its valid pulse, and `lost` is due one edge after the refusing cycle. The bench drives inputs on the falling edge and checks the views and `lost` shortly after. At that point the previous rising edge has settled and the current inputs have taken effect. A bench model then advances its stored value, lock and lost flag at the rising edge using the rules in R2, R6, R7 and R9.

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             left_adj,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [BUS_W-1:0] lo_byte,
  output logic [BUS_W-1:0] hi_byte,
  output logic             lost
);
  localparam int WIDE  = 2 * BUS_W;
  localparam int SHIFT = WIDE - RES_W;

  logic [RES_W-1:0] res_q;
  logic             lock_q;
  logic             hold;
  logic [WIDE-1:0]  wide;

  assign hold = (lock_q | rd_lo) & ~rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      lock_q <= 1'b0;
      lost   <= 1'b0;
    end else begin
      if (res_valid && !hold) res_q <= res_data;
      lost <= res_valid & hold;
      if (rd_hi)      lock_q <= 1'b0;
      else if (rd_lo) lock_q <= 1'b1;
    end
  end

  assign wide    = left_adj ? (WIDE'(res_q) << SHIFT) : WIDE'(res_q);
  assign lo_byte = wide[BUS_W-1:0];
  assign hi_byte = wide[WIDE-1:BUS_W];

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !hold) |=> (res_q == $past(res_data)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !rd_hi) |=> $stable(res_q));
  a_r6_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> lock_q);
  a_r7_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && hold) |=> lost);
  a_r7_no_lost: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && hold) |=> !lost);
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !lock_q);
  a_r3_unused: assert property (@(posedge clk) disable iff (!rst_n)
    !left_adj |-> (hi_byte >> (RES_W - BUS_W)) == '0);
  a_r4_unused: assert property (@(posedge clk) disable iff (!rst_n)
    left_adj |-> (lo_byte << (BUS_W - SHIFT)) == '0);
endmodule

// File: tb/sim_adc_result_latch.sv
module sim_adc_result_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] lo_byte, hi_byte;
  logic       lost;

  int tests = 0;
  int fails = 0;
  logic [9:0] m_res = '0;
  logic       m_lock = 1'b0;
  logic       m_lost = 1'b0;

  always #5 clk = ~clk;

  adc_result_latch u0 (.clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .lo_byte(lo_byte), .hi_byte(hi_byte),
    .lost(lost));

  function automatic logic [15:0] view(input logic [9:0] r, input logic adj);
    return adj ? {r[9:2], r[1:0], 6'b0} : {6'b0, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [9:0] d,
                      input logic lo, input logic hi, input logic adj);
    logic hold;
    @(negedge clk);
    res_valid = v; res_data = d; rd_lo = lo; rd_hi = hi; left_adj = adj;
    #1;
    check(tag, {hi_byte, lo_byte}, view(m_res, adj));
    check("R7", lost, m_lost);
    @(posedge clk);
    hold = (m_lock | lo) & ~hi;
    m_lost = v & hold;
    if (v && !hold) m_res = d;
    if (hi) m_lock = 1'b0;
    else if (lo) m_lock = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    check("R1", {hi_byte, lo_byte, lost}, 17'h0);
    rst_n = 1'b1;
    step("R1", 0, 10'h0, 0, 0, 0);
    step("R3", 1, 10'h3FF, 0, 0, 0);
    step("R2", 0, 10'h0, 0, 0, 0);
    check("R3", {hi_byte, lo_byte}, 16'h03FF);
    step("R4", 1, 10'h2C5, 0, 0, 1);
    step("R4", 0, 10'h0, 0, 0, 1);
    check("R4", {hi_byte, lo_byte}, 16'hB140);
    step("R5", 0, 10'h0, 0, 0, 0);
    check("R5", {hi_byte, lo_byte}, 16'h02C5);
    step("R6", 1, 10'h111, 1, 0, 0);
    step("R6", 1, 10'h222, 0, 0, 0);
    check("R6", {hi_byte, lo_byte}, 16'h02C5);
    check("R7", lost, 1'b1);
    step("R9", 1, 10'h155, 0, 1, 0);
    step("R9", 0, 10'h0, 0, 0, 0);
    check("R9", {hi_byte, lo_byte}, 16'h0155);
    check("R7", lost, 1'b0);
    step("R8", 0, 10'h0, 0, 1, 1);
    step("R8", 1, 10'h0AA, 0, 0, 1);
    step("R8", 0, 10'h0, 0, 0, 1);
    check("R8", {hi_byte, lo_byte}, 16'h2A80);
    step("R9", 0, 10'h0, 1, 1, 0);
    step("R9", 1, 10'h301, 0, 0, 0);
    step("R9", 0, 10'h0, 0, 0, 0);
    check("R9", {hi_byte, lo_byte}, 16'h0301);
    for (int i = 0; i < 3000; i++) begin
      logic adj;
      adj = $urandom_range(0, 1);
      step(adj ? "R4" : "R3", $urandom_range(0, 2) != 0, 10'($urandom),
           $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0, adj);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule